// File: doc/BRIEF.md
# CRC-Checked Debug Scan Data Register

This block is the target-side data register that sits behind the debug scan chain of a test access port. It runs entirely on the test clock. It takes the Capture-DR, Shift-DR and Update-DR enables from an external TAP controller, and it acts only while the 4-bit chain code equals 1. During Shift-DR it takes in a packet from TDI and keeps a running CRC-8 of the incoming bits. The packet holds a target address, a direction flag and a data word, followed by the host's CRC byte.

On a read, the addressed word is fetched from a simple combinational register/memory port the moment the direction bit arrives. That word is then shifted out on TDO, and a second CRC is built over the outgoing bits. During the final byte of the packet the register returns a CRC on TDO, so the host can confirm the transfer. On a write this is the CRC of what the register received. On a read it is the CRC of the data it sent.

Once the packet is complete, TDO holds a single status bit that tells whether the host's CRC matched. Update-DR commits a write to the port only when that bit is set. The host reads the status bit and repeats the transfer on a mismatch. TDO changes only on falling edges of the test clock.

Top module: `dbg_chain_reg`

## Requirements
- R1: After asynchronous reset, tdo_o, bus_we_o and bus_re_o are 0.
- R2: While chain_i equals 1 and shift_dr_i is high, one TDI bit is taken on each rising tck_i edge. The packet is 73 bits: a 32-bit address, a direction bit (1 = write, 0 = read), 32 data bits and an 8-bit CRC, each field MSB first. Bits beyond the 73rd are ignored.
- R3: The CRC-8 step for input bit d and state c is: bits 7..3 take c[6..2], bit2 = d^c1^c7, bit1 = d^c0^c7, bit0 = d^c7. Both running CRCs start from 0 at Capture-DR.
- R4: On a write, TDO carries MSB first, during the CRC field, the CRC of the 65 address, direction and data bits received.
- R5: On a read, bus_re_o is high for exactly one cycle, the one in which the direction bit 0 is shifted, with bus_addr_o holding the received address. The returned word then appears on TDO MSB first during the 32 data bit slots.
- R6: On a read, TDO carries MSB first, during the CRC field, the CRC of the 32 data bits sent on TDO.
- R7: From the falling edge after the final CRC bit until the next Capture-DR, TDO is 1 if the host CRC equals the CRC of the received address, direction and data bits, and 0 otherwise.
- R8: A complete write packet with a matching CRC gives one bus_we_o pulse in the cycle after the Update-DR edge, with bus_addr_o and bus_wdata_o holding the received address and data.
- R9: A write packet with a mismatched CRC issues no write, and the target word keeps its value.
- R10: With chain_i not equal to 1, the register ignores all enables: TDO stays 0 and neither strobe is issued.
- R11: An Update-DR that follows an incomplete packet issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_i | input | 4 | Selected scan-chain code; 1 selects this register |
| capture_dr_i | input | 1 | Capture-DR state enable |
| shift_dr_i | input | 1 | Shift-DR state enable |
| update_dr_i | input | 1 | Update-DR state enable |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, changes on falling tck_i |
| bus_addr_o | output | 32 | Received target address |
| bus_wdata_o | output | 32 | Received write data |
| bus_rdata_i | input | 32 | Combinational read data for bus_addr_o |
| bus_re_o | output | 1 | Read strobe |
| bus_we_o | output | 1 | Write strobe |

## Verification
The bench acts as the host and sends packets built from the requirements. It uses two address/data pairs with different low and high bits. This shows whether address and data are taken MSB first and whether a read returns the word that was written. Writes and reads are each checked on the returned CRC, so the received-bit CRC and the sent-data CRC are told apart. A single flipped bit in the host CRC, a packet sent while another chain is selected, and a packet cut short before Update-DR each show, by a read-back afterwards, that the stored word is unchanged.

// File: rtl/dbg_chain_pkg.sv
`timescale 1ns/1ps
package dbg_chain_pkg;

  localparam int unsigned CRC_W = 8;

  typedef enum logic [2:0] {
    FLD_ADDR,
    FLD_DIR,
    FLD_DATA,
    FLD_CRC,
    FLD_DONE
  } fld_e;

  // one serial step of x^8+x^2+x+1
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[7];
    crc8_step = {c[6:2], c[1] ^ fb, c[0] ^ fb, fb};
  endfunction

endpackage

// File: rtl/dbg_crc8.sv
`timescale 1ns/1ps
module dbg_crc8
  import dbg_chain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             d_i,
  output logic [CRC_W-1:0] q_o,
  output logic [CRC_W-1:0] nxt_o
);

  logic [CRC_W-1:0] crc_q;

  assign nxt_o = crc8_step(crc_q, d_i);
  assign q_o   = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= nxt_o;
  end

  // R3
  crc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));

endmodule

// File: rtl/dbg_chain_rx.sv
`timescale 1ns/1ps
module dbg_chain_rx
  import dbg_chain_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              tdi_i,
  output fld_e              field_o,
  output logic              data_last_o,
  output logic              crc_last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CRC_W-1:0]  hcrc_o
);

  localparam int unsigned PKT_BITS = ADDR_W + 1 + DATA_W + CRC_W;
  localparam int unsigned CNT_W    = $clog2(PKT_BITS + 1);
  localparam int unsigned DIR_POS  = ADDR_W;
  localparam int unsigned CRC_LO   = ADDR_W + 1 + DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  hcrc_q;
  logic              adv;

  always_comb begin
    if (cnt_q < CNT_W'(DIR_POS))       field_o = FLD_ADDR;
    else if (cnt_q == CNT_W'(DIR_POS)) field_o = FLD_DIR;
    else if (cnt_q < CNT_W'(CRC_LO))   field_o = FLD_DATA;
    else if (cnt_q < CNT_W'(PKT_BITS)) field_o = FLD_CRC;
    else                               field_o = FLD_DONE;
  end

  assign adv         = sel_i && shift_i && (field_o != FLD_DONE);
  assign data_last_o = adv && (cnt_q == CNT_W'(CRC_LO - 1));
  assign crc_last_o  = adv && (cnt_q == CNT_W'(PKT_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (sel_i && capture_i) cnt_q <= '0;
    else if (adv)                cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      data_q <= '0;
      hcrc_q <= '0;
    end else if (adv) begin
      unique case (field_o)
        FLD_ADDR: addr_q <= {addr_q[ADDR_W-2:0], tdi_i};
        FLD_DIR:  dir_q  <= tdi_i;
        FLD_DATA: data_q <= {data_q[DATA_W-2:0], tdi_i};
        FLD_CRC:  hcrc_q <= {hcrc_q[CRC_W-2:0], tdi_i};
        default:  ;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign dir_o  = dir_q;
  assign data_o = data_q;
  assign hcrc_o = hcrc_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PKT_BITS));

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && field_o == FLD_DATA) |=> $stable(dir_q));

endmodule

// File: rtl/dbg_chain_tx.sv
`timescale 1ns/1ps
module dbg_chain_tx
  import dbg_chain_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              load_rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              load_crc_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic              done_i,
  input  logic              ok_i,
  output logic              msb_o,
  output logic              tdo_o
);

  logic [DATA_W-1:0] out_q;
  logic              tdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 out_q <= '0;
    else if (sel_i && capture_i) out_q <= '0;
    else if (load_rd_i)          out_q <= rdata_i;
    else if (load_crc_i)         out_q <= DATA_W'(crc_i) << (DATA_W - CRC_W);
    else if (sel_i && shift_i)   out_q <= out_q << 1;
  end

  // launch on the falling edge so the host samples a settled bit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tdo_q <= 1'b0;
    else if (!sel_i) tdo_q <= 1'b0;
    else if (done_i) tdo_q <= ok_i;
    else             tdo_q <= out_q[DATA_W-1];
  end

  assign msb_o = out_q[DATA_W-1];
  assign tdo_o = tdo_q;

  // R5
  rd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rd_i |=> (out_q == $past(rdata_i)));

  // R4
  crc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_crc_i && !load_rd_i) |=> (out_q[DATA_W-1 -: CRC_W] == $past(crc_i)));

endmodule

// File: rtl/dbg_chain_reg.sv
`timescale 1ns/1ps
module dbg_chain_reg
  import dbg_chain_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAIN_W  = 4,
  parameter int unsigned CHAIN_ID = 1
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic [CHAIN_W-1:0] chain_i,
  input  logic               capture_dr_i,
  input  logic               shift_dr_i,
  input  logic               update_dr_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  output logic               bus_re_o,
  output logic               bus_we_o
);

  logic              sel;
  fld_e              field;
  logic              data_last, crc_last;
  logic [ADDR_W-1:0] addr;
  logic              dir;
  logic [DATA_W-1:0] data;
  logic [CRC_W-1:0]  hcrc;
  logic [CRC_W-1:0]  rx_crc, rx_nxt, tx_crc, tx_nxt;
  logic              rx_en, tx_en, crc_clr, tx_msb;
  logic              ok_q, we_q;

  assign sel     = (chain_i == CHAIN_W'(CHAIN_ID));
  assign crc_clr = sel && capture_dr_i;
  assign rx_en   = sel && shift_dr_i &&
                   (field == FLD_ADDR || field == FLD_DIR || field == FLD_DATA);
  assign tx_en   = sel && shift_dr_i && (field == FLD_DATA) && !dir;
  assign bus_re_o = sel && shift_dr_i && (field == FLD_DIR) && !tdi_i;

  dbg_chain_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .capture_i   (capture_dr_i),
    .shift_i     (shift_dr_i),
    .tdi_i       (tdi_i),
    .field_o     (field),
    .data_last_o (data_last),
    .crc_last_o  (crc_last),
    .addr_o      (addr),
    .dir_o       (dir),
    .data_o      (data),
    .hcrc_o      (hcrc)
  );

  dbg_crc8 u_rx_crc (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (rx_en),
    .d_i    (tdi_i),
    .q_o    (rx_crc),
    .nxt_o  (rx_nxt)
  );

  dbg_crc8 u_tx_crc (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (tx_en),
    .d_i    (tx_msb),
    .q_o    (tx_crc),
    .nxt_o  (tx_nxt)
  );

  dbg_chain_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (tck_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .capture_i  (capture_dr_i),
    .shift_i    (shift_dr_i),
    .load_rd_i  (bus_re_o),
    .rdata_i    (bus_rdata_i),
    .load_crc_i (data_last),
    .crc_i      (dir ? rx_nxt : tx_nxt),
    .done_i     (field == FLD_DONE),
    .ok_i       (ok_q),
    .msb_o      (tx_msb),
    .tdo_o      (tdo_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       ok_q <= 1'b0;
    else if (crc_clr)  ok_q <= 1'b0;
    else if (crc_last) ok_q <= ({hcrc[CRC_W-2:0], tdi_i} == rx_crc);
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b0;
    else         we_q <= sel && update_dr_i && ok_q && dir && (field == FLD_DONE);
  end

  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr;
  assign bus_wdata_o = data;

  // R8
  we_ok_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_we_o |-> (ok_q && dir));

  // R7
  ok_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!capture_dr_i && !crc_last) |=> $stable(ok_q));

  // R10
  desel_re_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel |-> !bus_re_o);

  // R5
  re_we_excl_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_re_o |-> !bus_we_o);

endmodule

// File: tb/sim_dbg_chain_reg.sv
`timescale 1ns/1ps
module sim_dbg_chain_reg;

  localparam int CLK_PERIOD = 10;

  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  chain = 4'd1;
  logic        cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic        tdo, re, we;
  logic [31:0] addr, wdata, rdata;
  logic [31:0] mem [16];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  dbg_chain_reg u0 (
    .tck_i(tck), .rst_ni(rst_n), .chain_i(chain),
    .capture_dr_i(cap), .shift_dr_i(sh), .update_dr_i(upd), .tdi_i(tdi),
    .tdo_o(tdo), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .bus_re_o(re), .bus_we_o(we)
  );

  assign rdata = mem[addr[3:0]];

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else if (we) begin
      mem[addr[3:0]] <= wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_bit(input logic [7:0] c, input logic d);
    logic [7:0] n;
    n = {c[6:0], 1'b0} & 8'hF8;
    n[0] = d ^ c[7];
    n[1] = d ^ c[0] ^ c[7];
    n[2] = d ^ c[1] ^ c[7];
    return n;
  endfunction

  function automatic logic [7:0] crc_pkt(input logic [72:0] p);
    logic [7:0] c = 8'h0;
    for (int i = 72; i >= 8; i--) c = crc_bit(c, p[i]);
    return c;
  endfunction

  function automatic logic [7:0] crc_word(input logic [31:0] w);
    logic [7:0] c = 8'h0;
    for (int i = 31; i >= 0; i--) c = crc_bit(c, w[i]);
    return c;
  endfunction

  logic s_tdo, s_re, s_we;

  task automatic step(input logic c, input logic s, input logic u, input logic d);
    @(negedge tck);
    #1;
    cap = c; sh = s; upd = u; tdi = d;
    #3;
    s_tdo = tdo; s_re = re; s_we = we;
  endtask

  // host transaction; nbits < 73 gives a truncated packet
  task automatic run_pkt(input logic [31:0] a, input logic dir, input logic [31:0] d,
                         input logic [7:0] crc_flip, input logic [3:0] ch, input int nbits,
                         output logic [31:0] rd, output logic [7:0] crc_got,
                         output logic ok, output int we_n, output int re_n,
                         output logic [31:0] a_we, output logic [31:0] d_we,
                         output logic tdo_any);
    logic [72:0] pkt;
    logic [72:0] seen;
    pkt = {a, dir, (dir ? d : 32'h0), 8'h0};
    pkt[7:0] = crc_pkt(pkt) ^ crc_flip;
    seen = '0; we_n = 0; re_n = 0; tdo_any = 1'b0; a_we = '0; d_we = '0;
    chain = ch;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < nbits; i++) begin
      step(1'b0, 1'b1, 1'b0, pkt[72-i]);
      seen[72-i] = s_tdo;
      tdo_any |= s_tdo;
      re_n += int'(s_re);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    tdo_any |= s_tdo;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    ok = s_tdo;
    tdo_any |= s_tdo;
    for (int k = 0; k < 2; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      if (s_we) begin
        we_n++; a_we = addr; d_we = wdata;
      end
    end
    chain = 4'd1;
    rd = seen[39:8];
    crc_got = seen[7:0];
  endtask

  logic [31:0] r_rd, r_a, r_d;
  logic [7:0]  r_crc;
  logic        r_ok, r_any;
  int          r_we, r_re;

  task automatic t_reset();
    #2;
    check(tdo == 1'b0, "R1", "tdo at reset", {31'h0, tdo}, 32'h0);
    check(we == 1'b0 && re == 1'b0, "R1", "strobes at reset", {30'h0, we, re}, 32'h0);
    repeat (2) @(negedge tck);
    rst_n = 1'b1;
  endtask

  task automatic t_write(input logic [31:0] a, input logic [31:0] d);
    logic [72:0] p;
    p = {a, 1'b1, d, 8'h0};
    run_pkt(a, 1'b1, d, 8'h0, 4'd1, 73, r_rd, r_crc, r_ok, r_we, r_re, r_a, r_d, r_any);
    check(r_crc == crc_pkt(p), "R3 R4", "write return crc", {24'h0, r_crc}, {24'h0, crc_pkt(p)});
    check(r_ok == 1'b1, "R7", "write ok bit", {31'h0, r_ok}, 32'h1);
    check(r_we == 1, "R8", "write strobe count", r_we, 32'd1);
    check(r_a == a, "R2", "write address", r_a, a);
    check(r_d == d, "R2", "write data", r_d, d);
    check(r_re == 0, "R5", "no read strobe on write", r_re, 32'd0);
  endtask

  task automatic t_read(input logic [31:0] a, input logic [31:0] exp);
    run_pkt(a, 1'b0, 32'h0, 8'h0, 4'd1, 73, r_rd, r_crc, r_ok, r_we, r_re, r_a, r_d, r_any);
    check(r_rd == exp, "R5", "read data on tdo", r_rd, exp);
    check(r_re == 1, "R5", "read strobe count", r_re, 32'd1);
    check(r_crc == crc_word(exp), "R3 R6", "read return crc", {24'h0, r_crc}, {24'h0, crc_word(exp)});
    check(r_ok == 1'b1, "R7", "read ok bit", {31'h0, r_ok}, 32'h1);
    check(r_we == 0, "R8", "no write on read", r_we, 32'd0);
  endtask

  task automatic t_bad_crc(input logic [31:0] a, input logic [31:0] d);
    run_pkt(a, 1'b1, d, 8'h01, 4'd1, 73, r_rd, r_crc, r_ok, r_we, r_re, r_a, r_d, r_any);
    check(r_ok == 1'b0, "R7", "ok bit on mismatch", {31'h0, r_ok}, 32'h0);
    check(r_we == 0, "R9", "write strobe on mismatch", r_we, 32'd0);
  endtask

  task automatic t_deselect(input logic [31:0] a, input logic [31:0] d);
    run_pkt(a, 1'b1, d, 8'h0, 4'd2, 73, r_rd, r_crc, r_ok, r_we, r_re, r_a, r_d, r_any);
    check(r_any == 1'b0, "R10", "tdo while deselected", {31'h0, r_any}, 32'h0);
    check(r_we == 0 && r_re == 0, "R10", "strobes while deselected", r_we + r_re, 32'd0);
  endtask

  task automatic t_short(input logic [31:0] a, input logic [31:0] d);
    run_pkt(a, 1'b1, d, 8'h0, 4'd1, 60, r_rd, r_crc, r_ok, r_we, r_re, r_a, r_d, r_any);
    check(r_we == 0, "R11", "write after short packet", r_we, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write(32'h0000_0005, 32'hA5C3_0F1E);
    t_read (32'h0000_0005, 32'hA5C3_0F1E);
    t_write(32'h8000_0009, 32'hFFFF_0001);
    t_read (32'h8000_0009, 32'hFFFF_0001);
    t_read (32'h0000_0005, 32'hA5C3_0F1E);
    t_bad_crc(32'h0000_0005, 32'h1234_5678);
    t_read (32'h0000_0005, 32'hA5C3_0F1E);   // R9 word unchanged
    t_deselect(32'h0000_0005, 32'hDEAD_BEEF);
    t_read (32'h0000_0005, 32'hA5C3_0F1E);   // R10 word unchanged
    t_short(32'h0000_0005, 32'h0BAD_F00D);
    t_read (32'h0000_0005, 32'hA5C3_0F1E);   // R11 word unchanged
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule